// File: doc/BRIEF.md
# PCI Master Data Parity Monitor

This block watches the data phases of a PCI bus master and handles data parity errors. On a read, it takes every data phase that both the initiator and the target complete. It folds the address/data and byte-enable lines of that phase into one parity bit. One clock later it compares that bit with the parity line. A mismatch always sets a sticky "parity error detected" status bit. When the host has enabled parity error response, a mismatch also sets a "parity error reported" status bit and drives the shared error line low on the following clock. The error line is a sustained tri-state signal, so the block drives it high for one clock before it releases it.

On a write, the target reports parity errors. While the master's write watch window is open, a sampled low on the incoming error line sets the same status bits. The reported bit is again gated by the enable. The block never drives the error line for a write.

Both status bits sit in a status word at fixed bit positions. The host clears each bit by writing a 1 to it. A bit that is set and cleared on the same edge stays set.

Top module: `pci_dpar_monitor`

## Requirements
- R1: While reset is asserted, and after it, until an error occurs: `perr_oe` is 0, `perr_n` is 1 and `stat_word` is all zero.
- R2: A read data phase is checked only when, at edge N, `rd_phase`=1, `irdy_n`=0 and `trdy_n`=0. The `ad` and `cbe` lines are sampled at edge N and `par` at edge N+1. An error is flagged when the XOR of `ad`, `cbe` and `par` is 1 (even parity). A phase without all three of those conditions is ignored, whatever the parity.
- R3: A read parity error sets `stat_word[15]` at edge N+1, whatever the value of `resp_en`.
- R4: When `resp_en`=1 at edge N+1, a read parity error also sets `stat_word[8]`, and the block drives `perr_oe`=1, `perr_n`=0 in the cycle sampled at edge N+2. When `resp_en`=0, it does neither.
- R5: After its last low cycle, the error line is driven high (`perr_oe`=1, `perr_n`=1) for exactly one cycle and then released (`perr_oe`=0). Errors on consecutive phases keep the line low without a high cycle in between.
- R6: If `wr_watch`=1 and `perr_in_n`=0 at an edge, that edge sets `stat_word[15]`. It also sets `stat_word[8]` when `resp_en`=1 at that edge. With `wr_watch`=0, `perr_in_n` has no effect. Write-side errors never drive the error line.
- R7: When `clr_wr`=1 at an edge, every bit of `stat_word` whose `clr_data` bit is 1 is cleared, and bits whose `clr_data` bit is 0 keep their value. All bits other than 15 and 8 always read 0.
- R8: A set and a clear of the same status bit on the same edge leave the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resp_en | input | 1 | Parity error response enable from the command register |
| rd_phase | input | 1 | Master is in a read data phase |
| wr_watch | input | 1 | Master is watching for target error reports on a write |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Address/data lines |
| cbe | input | 4 | Command/byte-enable lines |
| par | input | 1 | Parity line |
| perr_in_n | input | 1 | Incoming parity error line, active low |
| clr_wr | input | 1 | Host write strobe to the status word |
| clr_data | input | 16 | Host write data, a 1 clears that status bit |
| perr_n | output | 1 | Outgoing parity error level |
| perr_oe | output | 1 | Output enable for the error line |
| stat_word | output | 16 | Status word: bit 15 detected, bit 8 reported |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a status set and a host clear. The bench provokes this by raising a write-side error report while it writes all ones to the status word on the same edge, and it expects both bits to read 1 afterwards. The second pair is the high-drive cycle that follows a low cycle and a new read error. The bench runs two errored read phases back to back and expects two low cycles, then one high cycle, then release.

// File: rtl/pci_dpar_pkg.sv
package pci_dpar_pkg;

   // Output sequencer for the sustained tri-state error line
   typedef enum logic [1:0] {
      PERR_IDLE = 2'd0,
      PERR_LOW  = 2'd1,
      PERR_HIGH = 2'd2
   } perr_st_t;

   // One parity error event as seen by the status logic
   typedef struct packed {
      logic detect;
      logic report;
   } perr_evt_t;

endpackage

// File: rtl/pci_dpar_calc.sv
module pci_dpar_calc #(
   parameter int AD_W    = 32,
   parameter int BE_W    = 4,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic [AD_W-1:0] ad,
   input  logic [BE_W-1:0] cbe,
   input  logic            par,
   output logic            rd_err
);

   logic s1_vld;
   logic s1_sum;
   logic mism;

   // Stage 1: fold data and byte enables of the accepted phase
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_sum <= 1'b0;
      end else begin
         s1_vld <= accept;
         s1_sum <= ^{ad, cbe};
      end
   end

   // Parity line arrives one clock after the data
   assign mism = s1_sum ^ par;

   generate
      if (ODD_PAR) begin : g_odd
         assign rd_err = s1_vld & ~mism;
      end else begin : g_even
         assign rd_err = s1_vld & mism;
      end
   endgenerate

endmodule

// File: rtl/pci_perr_drive.sv
module pci_perr_drive
   import pci_dpar_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic assert_low,
   output logic perr_n,
   output logic perr_oe
);

   perr_st_t st_q;
   perr_st_t st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PERR_IDLE: st_d = assert_low ? PERR_LOW : PERR_IDLE;
         PERR_LOW:  st_d = assert_low ? PERR_LOW : PERR_HIGH;
         PERR_HIGH: st_d = assert_low ? PERR_LOW : PERR_IDLE;
         default:   st_d = PERR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= PERR_IDLE;
      else        st_q <= st_d;
   end

   assign perr_n  = (st_q != PERR_LOW);
   assign perr_oe = (st_q != PERR_IDLE);

endmodule

// File: rtl/pci_dpar_status.sv
module pci_dpar_status
   import pci_dpar_pkg::*;
#(
   parameter int STAT_W  = 16,
   parameter int DET_BIT = 15,
   parameter int REP_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  perr_evt_t         evt,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_data,
   output logic [STAT_W-1:0] stat_word
);

   localparam logic [STAT_W-1:0] DET_M  = STAT_W'(1) << DET_BIT;
   localparam logic [STAT_W-1:0] REP_M  = STAT_W'(1) << REP_BIT;
   localparam logic [STAT_W-1:0] IMPL_M = DET_M | REP_M;

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;

   assign set_vec = (evt.detect ? DET_M : '0) | (evt.report ? REP_M : '0);
   assign clr_vec = clr_wr ? clr_data : '0;

   // Set has priority over a write-one-to-clear on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= ((stat_q & ~clr_vec) | set_vec) & IMPL_M;
   end

   assign stat_word = stat_q;

endmodule

// File: rtl/pci_dpar_monitor.sv
module pci_dpar_monitor
   import pci_dpar_pkg::*;
#(
   parameter int AD_W    = 32,
   parameter bit ODD_PAR = 1'b0,
   parameter int STAT_W  = 16,
   parameter int DET_BIT = 15,
   parameter int REP_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resp_en,
   input  logic              rd_phase,
   input  logic              wr_watch,
   input  logic              irdy_n,
   input  logic              trdy_n,
   input  logic [AD_W-1:0]   ad,
   input  logic [AD_W/8-1:0] cbe,
   input  logic              par,
   input  logic              perr_in_n,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_data,
   output logic              perr_n,
   output logic              perr_oe,
   output logic [STAT_W-1:0] stat_word
);

   localparam int BE_W = AD_W / 8;

   generate
      if (AD_W % 8 != 0 || AD_W < 8) begin : g_bad_width
         $error("AD_W must be a positive multiple of 8");
      end
      if (DET_BIT >= STAT_W || REP_BIT >= STAT_W) begin : g_bad_pos
         $error("status bit position outside the status word");
      end
      if (DET_BIT == REP_BIT) begin : g_same_pos
         $error("detected and reported bits must differ");
      end
   endgenerate

   logic      accept;
   logic      rd_err;
   logic      wr_err;
   perr_evt_t evt;

   assign accept = rd_phase & ~irdy_n & ~trdy_n;
   assign wr_err = wr_watch & ~perr_in_n;

   pci_dpar_calc #(
      .AD_W    (AD_W),
      .BE_W    (BE_W),
      .ODD_PAR (ODD_PAR)
   ) i_calc (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .ad     (ad),
      .cbe    (cbe),
      .par    (par),
      .rd_err (rd_err)
   );

   pci_perr_drive i_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .assert_low (rd_err & resp_en),
      .perr_n     (perr_n),
      .perr_oe    (perr_oe)
   );

   assign evt.detect = rd_err | wr_err;
   assign evt.report = (rd_err | wr_err) & resp_en;

   pci_dpar_status #(
      .STAT_W  (STAT_W),
      .DET_BIT (DET_BIT),
      .REP_BIT (REP_BIT)
   ) i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .clr_wr    (clr_wr),
      .clr_data  (clr_data),
      .stat_word (stat_word)
   );

endmodule

// File: rtl/pci_dpar_monitor_chk.sv
module pci_dpar_monitor_chk #(
   parameter int STAT_W  = 16,
   parameter int DET_BIT = 15,
   parameter int REP_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              resp_en,
   input logic              wr_watch,
   input logic              perr_in_n,
   input logic              perr_n,
   input logic              perr_oe,
   input logic [STAT_W-1:0] stat_word
);

   // R4: a low cycle comes with both status bits set
   assert_low_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && !perr_n) |-> (stat_word[DET_BIT] && stat_word[REP_BIT]));

   // R4: the line is driven low only if the enable was 1 at the deciding edge
   assert_low_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && !perr_n) |-> $past(resp_en));

   // R4, R6: the reported bit rises only if the enable was 1 at the setting edge
   assert_report_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_word[REP_BIT]) |-> $past(resp_en));

   // R5: a low cycle is followed by a driven cycle
   assert_no_release_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && !perr_n) |=> perr_oe);

   // R5: release happens only after a cycle driven high
   assert_release_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_oe) |-> $past(perr_n));

   // R6, R8: a write-side report sets the detected bit even against a clear
   assert_write_report_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_watch && !perr_in_n) |=> stat_word[DET_BIT]);

endmodule

bind pci_dpar_monitor pci_dpar_monitor_chk #(
   .STAT_W  (STAT_W),
   .DET_BIT (DET_BIT),
   .REP_BIT (REP_BIT)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .resp_en   (resp_en),
   .wr_watch  (wr_watch),
   .perr_in_n (perr_in_n),
   .perr_n    (perr_n),
   .perr_oe   (perr_oe),
   .stat_word (stat_word)
);

// File: tb/test_pci_dpar_monitor.sv
module test_pci_dpar_monitor;

   localparam logic [15:0] DET = 16'h8000;
   localparam logic [15:0] REP = 16'h0100;

   // {resp_en, flip_par, cbe[3:0], ad[31:0]}
   localparam logic [37:0] VEC_TBL [0:7] = '{
      {1'b1, 1'b0, 4'h0, 32'h0000_0000},
      {1'b1, 1'b1, 4'h0, 32'h0000_0000},
      {1'b0, 1'b1, 4'hF, 32'hDEAD_BEEF},
      {1'b1, 1'b1, 4'h3, 32'h1234_5678},
      {1'b0, 1'b0, 4'h7, 32'hFFFF_FFFF},
      {1'b1, 1'b0, 4'h1, 32'h8000_0001},
      {1'b1, 1'b1, 4'hA, 32'hA5A5_5A5A},
      {1'b0, 1'b0, 4'h5, 32'h0F0F_F0F0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        resp_en = 1'b0;
   logic        rd_phase = 1'b0;
   logic        wr_watch = 1'b0;
   logic        irdy_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic [31:0] ad = '0;
   logic [3:0]  cbe = '0;
   logic        par = 1'b0;
   logic        perr_in_n = 1'b1;
   logic        clr_wr = 1'b0;
   logic [15:0] clr_data = '0;
   logic        perr_n;
   logic        perr_oe;
   logic [15:0] stat_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pci_dpar_monitor i_pci_dpar_monitor (
      .clk       (clk),
      .rst_n     (rst_n),
      .resp_en   (resp_en),
      .rd_phase  (rd_phase),
      .wr_watch  (wr_watch),
      .irdy_n    (irdy_n),
      .trdy_n    (trdy_n),
      .ad        (ad),
      .cbe       (cbe),
      .par       (par),
      .perr_in_n (perr_in_n),
      .clr_wr    (clr_wr),
      .clr_data  (clr_data),
      .perr_n    (perr_n),
      .perr_oe   (perr_oe),
      .stat_word (stat_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_line(input string req, input logic oe, input logic lvl);
      chk(req, {30'd0, perr_oe, perr_n}, {30'd0, oe, lvl});
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_wr = 1'b1;
      clr_data = 16'hFFFF;
      @(negedge clk);
      clr_wr = 1'b0;
      clr_data = '0;
   endtask

   // Drives one data phase; returns at the negedge after edge N+1
   task automatic read_phase(input logic [31:0] a, input logic [3:0] b, input logic flip,
                             input logic en, input logic ir_n, input logic tr_n);
      @(negedge clk);
      rd_phase = 1'b1; irdy_n = ir_n; trdy_n = tr_n;
      ad = a; cbe = b; resp_en = en;
      @(negedge clk);
      rd_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
      ad = ~a; cbe = ~b;
      par = (^{a, b}) ^ flip;
      @(negedge clk);
   endtask

   task automatic write_report(input logic watch, input logic en, input logic clr);
      @(negedge clk);
      wr_watch = watch; perr_in_n = 1'b0; resp_en = en;
      clr_wr = clr; clr_data = clr ? 16'hFFFF : 16'h0000;
      @(negedge clk);
      wr_watch = 1'b0; perr_in_n = 1'b1; clr_wr = 1'b0; clr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk_line("R1 line in reset", 1'b0, 1'b1);
      chk("R1 status in reset", {16'd0, stat_word}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_line("R1 line after reset", 1'b0, 1'b1);
      chk("R1 status after reset", {16'd0, stat_word}, 32'd0);

      // Table walk: R2, R3, R4, R5
      for (int i = 0; i < 8; i++) begin
         logic en;
         logic flip;
         logic low;
         en = VEC_TBL[i][37];
         flip = VEC_TBL[i][36];
         low = en & flip;
         read_phase(VEC_TBL[i][31:0], VEC_TBL[i][35:32], flip, en, 1'b0, 1'b0);
         chk_line("R4 low cycle", low, ~low);
         chk("R2 R3 detected bit", {31'd0, stat_word[15]}, {31'd0, flip});
         chk("R4 reported bit", {31'd0, stat_word[8]}, {31'd0, low});
         @(negedge clk);
         chk_line("R5 high cycle", low, 1'b1);
         @(negedge clk);
         chk_line("R5 released", 1'b0, 1'b1);
         clear_all();
         chk("R7 cleared", {16'd0, stat_word}, 32'd0);
      end

      // R2: target not ready, bad parity ignored
      read_phase(32'h1111_2222, 4'h6, 1'b1, 1'b1, 1'b0, 1'b1);
      chk("R2 trdy high ignored", {16'd0, stat_word}, 32'd0);
      chk_line("R2 trdy high no drive", 1'b0, 1'b1);
      // R2: initiator not ready, bad parity ignored
      read_phase(32'h3333_4444, 4'h9, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R2 irdy high ignored", {16'd0, stat_word}, 32'd0);

      // R5: back-to-back errored phases
      @(negedge clk);
      rd_phase = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
      ad = 32'hCAFE_0001; cbe = 4'h2; resp_en = 1'b1;
      @(negedge clk);
      par = ~(^{32'hCAFE_0001, 4'h2});
      ad = 32'hCAFE_0003; cbe = 4'hC;
      @(negedge clk);
      rd_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
      par = ~(^{32'hCAFE_0003, 4'hC});
      chk_line("R5 first low", 1'b1, 1'b0);
      @(negedge clk);
      chk_line("R5 second low, no high gap", 1'b1, 1'b0);
      @(negedge clk);
      chk_line("R5 single high", 1'b1, 1'b1);
      @(negedge clk);
      chk_line("R5 release after burst", 1'b0, 1'b1);
      clear_all();

      // R6: write-side reports
      write_report(1'b1, 1'b0, 1'b0);
      chk("R6 write report enable off", {16'd0, stat_word}, {16'd0, DET});
      chk_line("R6 write no drive", 1'b0, 1'b1);
      clear_all();
      write_report(1'b1, 1'b1, 1'b0);
      chk("R6 write report enable on", {16'd0, stat_word}, {16'd0, DET | REP});
      chk_line("R6 write no drive enabled", 1'b0, 1'b1);

      // R7: partial clears
      @(negedge clk);
      clr_wr = 1'b1; clr_data = 16'h0100;
      @(negedge clk);
      clr_wr = 1'b0; clr_data = '0;
      chk("R7 clear only reported", {16'd0, stat_word}, {16'd0, DET});
      @(negedge clk);
      clr_wr = 1'b1; clr_data = 16'h7FFF;
      @(negedge clk);
      clr_wr = 1'b0; clr_data = '0;
      chk("R7 zeros keep detected", {16'd0, stat_word}, {16'd0, DET});
      @(negedge clk);
      clr_wr = 1'b1; clr_data = 16'h8000;
      @(negedge clk);
      clr_wr = 1'b0; clr_data = '0;
      chk("R7 clear detected", {16'd0, stat_word}, 32'd0);

      // R6: window closed, incoming error ignored
      write_report(1'b0, 1'b1, 1'b0);
      chk("R6 window closed ignored", {16'd0, stat_word}, 32'd0);

      // R8: set and clear on the same edge
      write_report(1'b1, 1'b1, 1'b1);
      chk("R8 set wins over clear", {16'd0, stat_word}, {16'd0, DET | REP});
      clear_all();
      chk("R8 later clear works", {16'd0, stat_word}, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule